// File: doc/BRIEF.md
# Complementary Half-Bridge Drive Sequencer

This block is the digital timing core of a resonant half-bridge. An up/down counter traces a symmetric triangle whose half-period, in system clocks, is the frequency command after it has been clamped between a programmed shortest and longest half-period. The triangle direction sets which switch may conduct. The low-side enable can be on only while the ramp rises. The high-side enable can be on only while it falls. Each half begins with a programmable dead time in which both enables stay off. The two switches therefore conduct for equal times, 180 degrees apart.

An external loop supplies the frequency command and the dead-time count. They are taken only at the triangle valley, or while the generator is parked, so a half-cycle in progress is never shortened or stretched. A run input drops low to give burst idle, and a UVLO input forces the stage off. In both cases the outputs go low and the triangle is parked at its valley. Every restart therefore begins with a low-side pulse, which lets the bootstrap capacitor charge first. A phase flag reports the current ramp direction.

Top module: `hb_drive_seq`

## Requirements
- R1: `lo_en` and `hi_en` are never high in the same cycle.
- R2: With P the clamped half-period and D the sampled dead count, every low-side pulse and every high-side pulse in uninterrupted switching lasts exactly P-D cycles.
- R3: Every turn-on is preceded by exactly D cycles with both enables low, on the low-to-high hand-over and on the high-to-low hand-over alike.
- R4: `phase_up` is 1 on the rising ramp and 0 on the falling ramp. `lo_en` is high only when `phase_up`=1 and `hi_en` only when `phase_up`=0.
- R5: The switching period is 2P cycles, where P is `half_cmd` clamped into [HALF_MIN, HALF_MAX] (defaults 20 and 500).
- R6: `half_cmd` and `dead_cmd` are sampled only at the valley (the end of a falling ramp) or while the generator is parked. A change made mid-period leaves the rest of that period unchanged.
- R7: One cycle after `run` is sampled low, both enables are low and `phase_up`=1, and they stay so while `run` stays low. After `run` returns high, the first enable to rise is `lo_en`, exactly D+1 cycles after `run` is sampled high.
- R8: While `uvlo`=1, both enables are low from the next cycle on, even when `run`=1. After release, switching restarts with `lo_en` first, as in R7.
- R9: While `rst_n`=0, both enables are low and `phase_up`=1.
- R10: When D is greater than or equal to P, neither enable is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Supply-undervoltage force-off, active high |
| run | input | 1 | 1 = switch, 0 = burst idle |
| half_cmd | input | CNT_W | Requested half-period in clocks (frequency command) |
| dead_cmd | input | DT_W | Dead time in clocks |
| lo_en | output | 1 | Low-side gate enable |
| hi_en | output | 1 | High-side gate enable |
| phase_up | output | 1 | Ramp direction: 1 rising, 0 falling |

## Verification
Two functions can act in the same cycle. One is the park that `run` and `uvlo` cause. The other is the command sample that happens both while parked and at a valley. The bench raises `uvlo` in the very cycle that `run` rises and requires that no enable appears while `uvlo` holds. After release it requires a low-side pulse exactly D+1 cycles later, built from the commands present at that moment. In a separate case a new half-period and a new dead time are applied during a low-side pulse. The bench then requires the old values for the rest of that period and the new dead time from the next valley on.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Bound a requested half-period to the programmed range.
  function automatic int clamp_half(int cmd, int lo_lim, int hi_lim);
    if (cmd < lo_lim) return lo_lim;
    if (cmd > hi_lim) return hi_lim;
    return cmd;
  endfunction

  // Rising ramp: conduction once the count has passed the dead time.
  function automatic logic rise_window(int pos, int dead);
    return pos >= dead;
  endfunction

  // Falling ramp: conduction once the count has dropped dead steps below the peak.
  function automatic logic fall_window(int pos, int peak, int dead);
    return (pos + dead) <= peak;
  endfunction

endpackage

// File: rtl/hb_ramp.sv
module hb_ramp #(
  parameter int CNT_W    = 10,
  parameter int DT_W     = 6,
  parameter int HALF_MIN = 20,
  parameter int HALF_MAX = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] half_cmd,
  input  logic [DT_W-1:0]  dead_cmd,
  output logic [CNT_W-1:0] ramp_q,
  output logic [CNT_W-1:0] peak_q,
  output logic [DT_W-1:0]  dead_q,
  output logic             up_q,
  output logic             running_q,
  output logic             valley
);

  logic [CNT_W-1:0] half_clamped;
  logic             top_reached;
  logic             park;

  assign half_clamped = CNT_W'(hb_pkg::clamp_half(int'(half_cmd), HALF_MIN, HALF_MAX));
  assign top_reached  = up_q && (ramp_q == peak_q - CNT_W'(1));
  assign valley       = !up_q && (ramp_q == CNT_W'(1));
  assign park         = !running_q || !go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      ramp_q    <= '0;
      up_q      <= 1'b1;
      peak_q    <= CNT_W'(HALF_MIN);
      dead_q    <= '0;
    end else begin
      running_q <= go;
      if (park || valley) begin
        ramp_q <= '0;
        up_q   <= 1'b1;
        peak_q <= half_clamped;
        dead_q <= dead_cmd;
      end else if (top_reached) begin
        ramp_q <= peak_q;
        up_q   <= 1'b0;
      end else if (up_q) begin
        ramp_q <= ramp_q + CNT_W'(1);
      end else begin
        ramp_q <= ramp_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/hb_gate.sv
module hb_gate #(
  parameter int  CNT_W     = 10,
  parameter int  DT_W      = 6,
  parameter bit  HIGH_SIDE = 1'b0
) (
  input  logic             running,
  input  logic             up,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] peak,
  input  logic [DT_W-1:0]  dead,
  output logic             en
);

  generate
    if (HIGH_SIDE) begin : g_high
      assign en = running && !up &&
                  hb_pkg::fall_window(int'(ramp), int'(peak), int'(dead));
    end else begin : g_low
      assign en = running && up &&
                  hb_pkg::rise_window(int'(ramp), int'(dead));
    end
  endgenerate

endmodule

// File: rtl/hb_drive_seq.sv
module hb_drive_seq #(
  parameter int CNT_W    = 10,
  parameter int DT_W     = 6,
  parameter int HALF_MIN = 20,
  parameter int HALF_MAX = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo,
  input  logic             run,
  input  logic [CNT_W-1:0] half_cmd,
  input  logic [DT_W-1:0]  dead_cmd,
  output logic             lo_en,
  output logic             hi_en,
  output logic             phase_up
);

  logic [CNT_W-1:0] ramp_q;
  logic [CNT_W-1:0] peak_q;
  logic [DT_W-1:0]  dead_q;
  logic             up_q;
  logic             running;
  logic             valley;
  logic             go;

  assign go = run && !uvlo;

  hb_ramp #(
    .CNT_W(CNT_W), .DT_W(DT_W), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .go(go),
    .half_cmd(half_cmd), .dead_cmd(dead_cmd),
    .ramp_q(ramp_q), .peak_q(peak_q), .dead_q(dead_q),
    .up_q(up_q), .running_q(running), .valley(valley)
  );

  hb_gate #(.CNT_W(CNT_W), .DT_W(DT_W), .HIGH_SIDE(1'b0)) u_lo (
    .running(running), .up(up_q), .ramp(ramp_q), .peak(peak_q),
    .dead(dead_q), .en(lo_en)
  );

  hb_gate #(.CNT_W(CNT_W), .DT_W(DT_W), .HIGH_SIDE(1'b1)) u_hi (
    .running(running), .up(up_q), .ramp(ramp_q), .peak(peak_q),
    .dead(dead_q), .en(hi_en)
  );

  assign phase_up = up_q;

endmodule

// File: rtl/hb_drive_chk.sv
module hb_drive_chk #(
  parameter int DT_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            uvlo,
  input logic            run,
  input logic            lo_en,
  input logic            hi_en,
  input logic            phase_up,
  input logic            running,
  input logic [DT_W-1:0] dead_q
);

  logic [15:0] gap_cnt;
  logic [15:0] lo_len;
  logic [15:0] hi_len;
  logic        lo_prev;
  logic        hi_prev;
  logic        lo_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= 16'hFFFF;
      lo_len  <= '0;
      hi_len  <= '0;
      lo_prev <= 1'b0;
      hi_prev <= 1'b0;
      lo_seen <= 1'b0;
    end else begin
      lo_prev <= lo_en;
      hi_prev <= hi_en;
      if (lo_en || hi_en)        gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
      if (lo_en) lo_len <= lo_prev ? lo_len + 16'd1 : 16'd1;
      if (hi_en) hi_len <= hi_prev ? hi_len + 16'd1 : 16'd1;
      if (!running)   lo_seen <= 1'b0;
      else if (lo_en) lo_seen <= 1'b1;
    end
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_en && hi_en));

  // R4
  lo_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_en |-> phase_up);

  // R4
  hi_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |-> !phase_up);

  // R3
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_en) || $rose(hi_en)) |-> (gap_cnt >= 16'(dead_q)));

  // R2
  equal_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hi_en) && running) |-> (hi_len == lo_len));

  // R7
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lo_en && !hi_en && phase_up));

  // R7
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_en) |-> lo_seen);

  // R8
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!lo_en && !hi_en));

endmodule

bind hb_drive_seq hb_drive_chk #(.DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .run(run),
  .lo_en(lo_en), .hi_en(hi_en), .phase_up(phase_up),
  .running(running), .dead_q(dead_q)
);

// File: tb/sim_hb_drive_seq.sv
module sim_hb_drive_seq;

  localparam int CNT_W    = 10;
  localparam int DT_W     = 6;
  localparam int HALF_MIN = 20;
  localparam int HALF_MAX = 500;
  localparam int NV       = 6;
  localparam int V_CMD [NV]  = '{40, 100, 5, 900, 30, 64};
  localparam int V_DEAD [NV] = '{15, 15, 15, 15, 0, 31};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             uvlo = 1'b0;
  logic             run = 1'b0;
  logic [CNT_W-1:0] half_cmd = CNT_W'(40);
  logic [DT_W-1:0]  dead_cmd = DT_W'(15);
  logic             lo_en, hi_en, phase_up;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hb_drive_seq #(
    .CNT_W(CNT_W), .DT_W(DT_W), .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .run(run),
    .half_cmd(half_cmd), .dead_cmd(dead_cmd),
    .lo_en(lo_en), .hi_en(hi_en), .phase_up(phase_up)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_half(int cmd);
    int p;
    p = cmd;
    if (p > HALF_MAX) p = HALF_MAX;
    if (p < HALF_MIN) p = HALF_MIN;
    return p;
  endfunction

  // One full period from a low-side rising edge, sampled at falling clock edges.
  task automatic meas(output int lo_on, output int g1, output int hi_on,
                      output int g2, output int lo_ph, output int hi_ph);
    while (lo_en) @(negedge clk);
    while (!lo_en) @(negedge clk);
    lo_ph = int'(phase_up);
    lo_on = 0;
    while (lo_en) begin lo_on++; @(negedge clk); end
    g1 = 0;
    while (!hi_en) begin g1++; @(negedge clk); end
    hi_ph = int'(phase_up);
    hi_on = 0;
    while (hi_en) begin hi_on++; @(negedge clk); end
    g2 = 0;
    while (!lo_en) begin g2++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lo_on, g1, hi_on, g2, lo_ph, hi_ph, p, d, n, hits;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 lo_en in reset", int'(lo_en), 0);
    chk("R9 hi_en in reset", int'(hi_en), 0);
    chk("R9 phase_up in reset", int'(phase_up), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      run = 1'b0;
      half_cmd = CNT_W'(V_CMD[i]);
      dead_cmd = DT_W'(V_DEAD[i]);
      repeat (2) @(negedge clk);
      run = 1'b1;
      p = exp_half(V_CMD[i]);
      d = V_DEAD[i];
      meas(lo_on, g1, hi_on, g2, lo_ph, hi_ph);
      chk("R2 low on-time", lo_on, p - d);
      chk("R2 high on-time", hi_on, p - d);
      chk("R3 dead low-to-high", g1, d);
      chk("R3 dead high-to-low", g2, d);
      chk("R5 period", lo_on + g1 + hi_on + g2, 2 * p);
      chk("R4 phase during low", lo_ph, 1);
      chk("R4 phase during high", hi_ph, 0);
    end

    // R6: mid-period command change takes effect at the next valley
    run = 1'b0;
    half_cmd = CNT_W'(40);
    dead_cmd = DT_W'(10);
    repeat (2) @(negedge clk);
    run = 1'b1;
    while (!lo_en) @(negedge clk);
    half_cmd = CNT_W'(60);
    dead_cmd = DT_W'(5);
    while (lo_en) @(negedge clk);
    g1 = 0;
    while (!hi_en) begin g1++; @(negedge clk); end
    hi_on = 0;
    while (hi_en) begin hi_on++; @(negedge clk); end
    g2 = 0;
    while (!lo_en) begin g2++; @(negedge clk); end
    lo_on = 0;
    while (lo_en) begin lo_on++; @(negedge clk); end
    chk("R6 old dead kept", g1, 10);
    chk("R6 old high on-time kept", hi_on, 30);
    chk("R6 new dead after valley", g2, 5);
    chk("R6 new low on-time", lo_on, 55);

    // R7: burst idle during a high-side pulse, then restart low side first
    while (!hi_en) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R7 lo off in idle", int'(lo_en), 0);
    chk("R7 hi off in idle", int'(hi_en), 0);
    chk("R7 phase parked", int'(phase_up), 1);
    hits = 0;
    repeat (10) begin @(negedge clk); hits += int'(lo_en) + int'(hi_en); end
    chk("R7 held off while idle", hits, 0);
    run = 1'b1;
    n = 0;
    while (!lo_en && !hi_en) begin n++; @(negedge clk); end
    chk("R7 low side first", int'(lo_en), 1);
    chk("R7 restart delay", n, 5 + 1);

    // R8: uvlo rising together with run dominates
    run = 1'b0;
    @(negedge clk);
    uvlo = 1'b1;
    run = 1'b1;
    hits = 0;
    repeat (20) begin @(negedge clk); hits += int'(lo_en) + int'(hi_en); end
    chk("R8 forced off under uvlo", hits, 0);
    uvlo = 1'b0;
    n = 0;
    while (!lo_en && !hi_en) begin n++; @(negedge clk); end
    chk("R8 low side first after uvlo", int'(lo_en), 1);
    chk("R8 restart delay", n, 5 + 1);
    // R8: uvlo during a low-side pulse
    @(negedge clk);
    uvlo = 1'b1;
    @(negedge clk);
    chk("R8 low cut next cycle", int'(lo_en) + int'(hi_en), 0);
    uvlo = 1'b0;

    // R10: dead time not below half-period
    run = 1'b0;
    half_cmd = CNT_W'(25);
    dead_cmd = DT_W'(25);
    repeat (2) @(negedge clk);
    run = 1'b1;
    hits = 0;
    repeat (200) begin @(negedge clk); hits += int'(lo_en) + int'(hi_en); end
    chk("R10 dead equal to peak", hits, 0);
    run = 1'b0;
    dead_cmd = DT_W'(40);
    repeat (2) @(negedge clk);
    run = 1'b1;
    hits = 0;
    repeat (200) begin @(negedge clk); hits += int'(lo_en) + int'(hi_en); end
    chk("R10 dead above peak", hits, 0);

    // R1: overlap scan across a running window
    run = 1'b0;
    half_cmd = CNT_W'(22);
    dead_cmd = DT_W'(0);
    repeat (2) @(negedge clk);
    run = 1'b1;
    hits = 0;
    repeat (300) begin @(negedge clk); hits += int'(lo_en && hi_en); end
    chk("R1 no overlap", hits, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule